// File: doc/BRIEF.md
# Smart Card T=0 Character Transceiver

This block moves single characters over the one-wire, open-drain I/O line of a contact smart card running the T=0 character protocol. It runs in one direction at a time. The block is the bus master and drives the card clock. When transmitting, it takes a byte from a one-entry holding register and sends the fixed frame on the line. When receiving, it finds the start bit, samples each bit at mid-bit and checks parity. It places good characters in a receive register.

The two directions handle errors with a handshake in the guard time. A receiver that sees bad parity pulls the line low for one bit time at the start of the guard time, and it discards the character. A transmitter always releases the line during the guard time. It looks for that low pulse from the card and records it in a sticky flag. Parity sense and bit order are set by configuration inputs. The bit time is a programmable count of card-clock periods.

Top module: `sc_t0_xcvr`

## Requirements
- R1: A transmitted character is a low start bit, eight data bits, one parity bit and a two-bit guard time with the line released. Each bit lasts `etu_div` card-clock periods, and `etu_div` must be 4 or more.
- R2: With `par_inv` low, the parity bit makes the count of ones over data and parity even. With `par_inv` high, that count is odd. The same rule is checked on receive.
- R3: With `msb_first` low, data bit 0 goes first on the line. With it high, data bit 7 goes first. The receiver assembles bytes in the same order.
- R4: The transmitter never pulls the line low during the guard time. It samples the line near the middle of the first guard bit. A low level there sets the sticky `nack_seen` flag, and the transmitter then waits one more bit time before it can start again.
- R5: The receiver starts on a high-to-low edge of the line while idle and samples at mid-bit. A character with correct parity is written to `rx_data` and sets `rx_ready`. A pulse on `rx_rd` clears `rx_ready`.
- R6: A received character with wrong parity pulls `io_pull_low` high for one bit time, starting where the guard time starts. It sets the sticky `par_err` flag. It leaves `rx_data` unchanged and does not set `rx_ready`.
- R7: `tx_empty` is high when the holding register can take a byte. `tx_wr` while `tx_empty` is low is ignored.
- R8: While `rx_en` and `tx_en` are both high, the transmitter does not start a character. The two directions never pull the line low at the same time.
- R9: `card_clk` runs freely with a period of 2*CK_HALF system clocks.
- R10: After reset, `tx_empty` is 1. `rx_ready`, `par_err`, `nack_seen`, `io_pull_low` and `card_clk` are all 0.
- R11: A pulse on `flag_clr` clears `par_err` and `nack_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive direction enable |
| tx_en | input | 1 | Transmit direction enable |
| msb_first | input | 1 | 1: data bit 7 first on the line |
| par_inv | input | 1 | 1: odd parity instead of even |
| etu_div | input | ETU_W | Card-clock periods per bit |
| tx_data | input | 8 | Byte to send |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_empty | output | 1 | Holding register can take a byte |
| rx_data | output | 8 | Last good received byte |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_ready | output | 1 | A good byte is waiting |
| flag_clr | input | 1 | Clears the sticky error flags |
| par_err | output | 1 | Sticky: a received character failed parity |
| nack_seen | output | 1 | Sticky: the card signalled an error after a sent character |
| card_clk | output | 1 | Clock to the card |
| io_in | input | 1 | Level of the I/O line |
| io_pull_low | output | 1 | 1 pulls the I/O line low; 0 releases it |

## Verification
The hardest case to reach is the card's error signal on a sent character. The low pulse must fall inside the first guard bit. That window is only known once the transmitter has aligned its start bit to a card-clock edge. The bench acts as the card. It waits for the start edge on the line, counts whole bit times from there, and pulls the line low inside the first guard bit. At the half-bit point it also confirms that the block itself has released the line. For receive errors, the bench sends frames with the parity bit deliberately flipped. It then watches for the block's low pulse at the start of the guard time.

// File: rtl/sc_t0_pkg.sv
// Shared state types for the T=0 character transceiver.
package sc_t0_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_G1, TX_G2, TX_G3
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_NACK
    } rx_st_e;
endpackage

// File: rtl/sc_t0_clkgen.sv
// Card clock generator: divides clk by 2*CK_HALF and gives a one-cycle
// tick right after each rising edge of the card clock.
// Assumes CK_HALF >= 1.
module sc_t0_clkgen #(
    parameter int CK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic card_clk,
    output logic ck_tick
);
    localparam int CW = (CK_HALF > 1) ? $clog2(CK_HALF) : 1;

    logic [CW-1:0] cnt;

    // Half-period counter, clock toggle and rising-edge tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            card_clk <= 1'b0;
            ck_tick  <= 1'b0;
        end else begin
            ck_tick <= 1'b0;
            if (cnt == CW'(CK_HALF - 1)) begin
                cnt      <= '0;
                card_clk <= ~card_clk;
                ck_tick  <= ~card_clk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ck_tick |-> $rose(card_clk)); // R9
endmodule

// File: rtl/sc_t0_etu.sv
// Bit timer: counts card-clock ticks within one bit time and flags the
// mid-bit tick and the last tick of the bit. Held at zero by restart.
// Assumes etu_div >= 4.
module sc_t0_etu #(
    parameter int ETU_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ck_tick,
    input  logic [ETU_W-1:0] etu_div,
    output logic             mid,
    output logic             last
);
    logic [ETU_W-1:0] cnt;

    assign mid  = ck_tick && (cnt == (etu_div >> 1));
    assign last = ck_tick && (cnt == etu_div - ETU_W'(1));

    // Tick counter, wraps at the end of each bit
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (last)    cnt <= '0;
        else if (ck_tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sc_t0_tx.sv
// Transmit side: one-byte holding register, frame serializer, guard-time
// release and card error sampling. Starts only on a card-clock tick so that
// every bit, the first included, lasts exactly etu_div ticks.
// Assumes msb_first and par_inv are stable during a character.
module sc_t0_tx
    import sc_t0_pkg::*;
#(
    parameter int ETU_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ck_tick,
    input  logic [ETU_W-1:0] etu_div,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             msb_first,
    input  logic             par_inv,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             line_in,
    input  logic             flag_clr,
    output logic             tx_empty,
    output logic             busy,
    output logic             pull_low,
    output logic             nack_seen
);
    tx_st_e     st;
    logic [7:0] hold;
    logic       full;
    logic [7:0] sh;
    logic [2:0] idx;
    logic       pbit;
    logic       nack_cur;
    logic       mid, last, go, cur;

    sc_t0_etu #(.ETU_W(ETU_W)) u_etu (
        .clk(clk), .rst_n(rst_n), .restart(st == TX_IDLE), .ck_tick(ck_tick),
        .etu_div(etu_div), .mid(mid), .last(last)
    );

    assign go       = (st == TX_IDLE) && full && tx_en && !rx_en && ck_tick;
    assign tx_empty = !full;
    assign busy     = (st != TX_IDLE);
    assign cur      = msb_first ? sh[7] : sh[0];

    // Line drive: only start, data and parity bits may pull low
    always_comb begin
        case (st)
            TX_START: pull_low = 1'b1;
            TX_DATA:  pull_low = !cur;
            TX_PAR:   pull_low = !pbit;
            default:  pull_low = 1'b0;
        endcase
    end

    // Holding register: accepts a write only when empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (go) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            hold <= wdata;
            full <= 1'b1;
        end
    end

    // Frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= TX_IDLE;
            sh       <= '0;
            idx      <= '0;
            pbit     <= 1'b0;
            nack_cur <= 1'b0;
        end else begin
            case (st)
                TX_IDLE: if (go) begin
                    sh       <= hold;
                    pbit     <= (^hold) ^ par_inv;
                    idx      <= '0;
                    nack_cur <= 1'b0;
                    st       <= TX_START;
                end
                TX_START: if (last) st <= TX_DATA;
                TX_DATA: if (last) begin
                    sh  <= msb_first ? {sh[6:0], 1'b0} : {1'b0, sh[7:1]};
                    idx <= idx + 1'b1;
                    if (idx == 3'd7) st <= TX_PAR;
                end
                TX_PAR: if (last) st <= TX_G1;
                TX_G1: begin
                    if (mid && !line_in) nack_cur <= 1'b1;
                    if (last) st <= TX_G2;
                end
                TX_G2: if (last) st <= nack_cur ? TX_G3 : TX_IDLE;
                TX_G3: if (last) st <= TX_IDLE;
                default: st <= TX_IDLE;
            endcase
        end
    end

    // Sticky record of the card's error signal
    always_ff @(posedge clk) begin
        if (!rst_n)                                 nack_seen <= 1'b0;
        else if (flag_clr)                          nack_seen <= 1'b0;
        else if (st == TX_G1 && mid && !line_in)    nack_seen <= 1'b1;
    end

    AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr && tx_empty |=> !tx_empty); // R7
    AST_TX_HOLD_OFF_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_IDLE) && rx_en |=> st == TX_IDLE); // R8
    AST_TX_NACK_IN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_seen) |-> $past(st) == TX_G1); // R4
endmodule

// File: rtl/sc_t0_rx.sv
// Receive side: start-edge detection, mid-bit sampling, parity check,
// one-bit low error pulse at guard start, and the receive register.
// Assumes line_in is already synchronized and etu_div >= 4.
module sc_t0_rx
    import sc_t0_pkg::*;
#(
    parameter int ETU_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ck_tick,
    input  logic [ETU_W-1:0] etu_div,
    input  logic             rx_en,
    input  logic             tx_busy,
    input  logic             msb_first,
    input  logic             par_inv,
    input  logic             line_in,
    input  logic             rd,
    input  logic             flag_clr,
    output logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             par_err,
    output logic             pull_low
);
    rx_st_e     st;
    logic [7:0] sh;
    logic [2:0] idx;
    logic       bad;
    logic       line_prev;
    logic       mid, last, start_edge, good_end, bad_end;

    sc_t0_etu #(.ETU_W(ETU_W)) u_etu (
        .clk(clk), .rst_n(rst_n), .restart(st == RX_IDLE), .ck_tick(ck_tick),
        .etu_div(etu_div), .mid(mid), .last(last)
    );

    assign start_edge = rx_en && !tx_busy && (st == RX_IDLE) && line_prev && !line_in;
    assign good_end   = (st == RX_PAR) && last && !bad;
    assign bad_end    = (st == RX_PAR) && last && bad;
    assign pull_low   = (st == RX_NACK);

    // Previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= line_in;
    end

    // Frame sequencer and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RX_IDLE;
            sh  <= '0;
            idx <= '0;
            bad <= 1'b0;
        end else if (!rx_en) begin
            st <= RX_IDLE;
        end else begin
            case (st)
                RX_IDLE: if (start_edge) st <= RX_START;
                RX_START: begin
                    if (mid && line_in) st <= RX_IDLE;
                    else if (last) begin
                        idx <= '0;
                        st  <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (mid) sh <= msb_first ? {sh[6:0], line_in} : {line_in, sh[7:1]};
                    if (last) begin
                        idx <= idx + 1'b1;
                        if (idx == 3'd7) st <= RX_PAR;
                    end
                end
                RX_PAR: begin
                    if (mid) bad <= (^sh) ^ line_in ^ par_inv;
                    if (last) st <= bad ? RX_NACK : RX_IDLE;
                end
                RX_NACK: if (last) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    // Receive register and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (good_end) begin
            rx_data  <= sh;
            rx_ready <= 1'b1;
        end else if (rd) begin
            rx_ready <= 1'b0;
        end
    end

    // Sticky parity error flag
    always_ff @(posedge clk) begin
        if (!rst_n)        par_err <= 1'b0;
        else if (flag_clr) par_err <= 1'b0;
        else if (bad_end)  par_err <= 1'b1;
    end

    AST_RX_KEEP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        st == RX_NACK |=> $stable(rx_data)); // R6
    AST_RX_READY_AFTER_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(st) == RX_PAR); // R5
    AST_RX_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) && !$past(flag_clr) |-> par_err); // R6
endmodule

// File: rtl/sc_t0_xcvr.sv
// Top level: card clock, line synchronizer, and the two direction engines
// sharing one open-drain line. The receiver is held off while the
// transmitter is busy, and the transmitter while the receiver is enabled.
module sc_t0_xcvr #(
    parameter int ETU_W   = 8,
    parameter int CK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             msb_first,
    input  logic             par_inv,
    input  logic [ETU_W-1:0] etu_div,
    input  logic [7:0]       tx_data,
    input  logic             tx_wr,
    output logic             tx_empty,
    output logic [7:0]       rx_data,
    input  logic             rx_rd,
    output logic             rx_ready,
    input  logic             flag_clr,
    output logic             par_err,
    output logic             nack_seen,
    output logic             card_clk,
    input  logic             io_in,
    output logic             io_pull_low
);
    logic [1:0] sync;
    logic       line, ck_tick, tx_busy, tx_low, rx_low;

    // Two-stage synchronizer on the line input, idles high
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], io_in};
    end
    assign line = sync[1];

    sc_t0_clkgen #(.CK_HALF(CK_HALF)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .ck_tick(ck_tick)
    );

    sc_t0_tx #(.ETU_W(ETU_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .ck_tick(ck_tick), .etu_div(etu_div),
        .tx_en(tx_en), .rx_en(rx_en), .msb_first(msb_first), .par_inv(par_inv),
        .wr(tx_wr), .wdata(tx_data), .line_in(line), .flag_clr(flag_clr),
        .tx_empty(tx_empty), .busy(tx_busy), .pull_low(tx_low),
        .nack_seen(nack_seen)
    );

    sc_t0_rx #(.ETU_W(ETU_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ck_tick(ck_tick), .etu_div(etu_div),
        .rx_en(rx_en), .tx_busy(tx_busy), .msb_first(msb_first),
        .par_inv(par_inv), .line_in(line), .rd(rx_rd), .flag_clr(flag_clr),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
        .pull_low(rx_low)
    );

    assign io_pull_low = tx_low | rx_low;

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_low && rx_low)); // R8
endmodule

// File: tb/sc_t0_xcvr_bench.sv
module sc_t0_xcvr_bench;
    localparam int ETU  = 8;
    localparam int CKH  = 2;
    localparam int BIT  = ETU * 2 * CKH;
    localparam int HALF = BIT / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 0, tx_en = 0, msb_first = 0, par_inv = 0;
    logic [7:0] etu_div = 8'(ETU);
    logic [7:0] tx_data = '0;
    logic tx_wr = 0, rx_rd = 0, flag_clr = 0, card_low = 0;
    logic tx_empty, rx_ready, par_err, nack_seen, card_clk, io_pull_low, io_in;
    logic [7:0] rx_data;

    int checks = 0, errors = 0;
    logic done = 1'b0;
    logic [7:0] last_good = 8'h00;

    always #2.5 clk = ~clk;
    assign io_in = ~(io_pull_low | card_low);

    sc_t0_xcvr #(.ETU_W(8), .CK_HALF(CKH)) u_sc_t0_xcvr (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .msb_first(msb_first), .par_inv(par_inv), .etu_div(etu_div),
        .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_rd(rx_rd), .rx_ready(rx_ready),
        .flag_clr(flag_clr), .par_err(par_err), .nack_seen(nack_seen),
        .card_clk(card_clk), .io_in(io_in), .io_pull_low(io_pull_low)
    );

    // Vector layout: {rx_dir, data[7:0], msb_first, par_inv, error}
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 8'hA5, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'h3C, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h01, 1'b0, 1'b1, 1'b0},
        {1'b0, 8'hF0, 1'b1, 1'b1, 1'b1},
        {1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'hC3, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h7E, 1'b0, 1'b0, 1'b1},
        {1'b1, 8'h80, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'h0F, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; ticks(1); flag_clr = 1'b0; ticks(1);
    endtask

    // Acts as the card receiving one character; optionally signals an error
    task automatic tx_capture(input logic [7:0] d, input logic msb, input logic inv,
                              input logic nack);
        int w;
        logic [7:0] got;
        logic b, pb;
        w = 0;
        got = '0;
        while (!io_pull_low && w < 400) begin ticks(1); w++; end
        chk(io_pull_low == 1'b1, "R1 start bit seen", int'(io_pull_low), 1);
        ticks(HALF);
        for (int k = 0; k < 8; k++) begin
            ticks(BIT);
            b = !io_pull_low;
            if (msb) got[7-k] = b; else got[k] = b;
        end
        ticks(BIT);
        pb = !io_pull_low;
        chk(got == d, msb ? "R3 tx msb-first data" : "R1 tx lsb-first data", got, d);
        chk(pb == ((^d) ^ inv), "R2 tx parity bit", pb, (^d) ^ inv);
        ticks(HALF + 2);
        card_low = nack;
        ticks(HALF - 2);
        chk(io_pull_low == 1'b0, "R4 line released in guard", io_pull_low, 0);
        ticks(HALF + 2);
        card_low = 1'b0;
        ticks(2 * BIT + HALF - 2);
        chk(nack_seen == nack, "R4 nack flag", nack_seen, nack);
        chk(tx_empty == 1'b1, "R7 holding empty after send", tx_empty, 1);
    endtask

    // Acts as the card sending one character
    task automatic rx_send(input logic [7:0] d, input logic msb, input logic inv,
                           input logic err);
        logic [9:0] fr;
        fr[0] = 1'b0;
        for (int k = 0; k < 8; k++) fr[k+1] = msb ? d[7-k] : d[k];
        fr[9] = (^d) ^ inv ^ err;
        for (int k = 0; k < 10; k++) begin
            card_low = !fr[k];
            ticks(BIT);
        end
        card_low = 1'b0;
        ticks(HALF);
        chk(io_pull_low == err, err ? "R6 error pulse at guard" : "R5 no pulse on good char",
            io_pull_low, err);
        ticks(BIT + HALF);
        chk(io_pull_low == 1'b0, "R6 pulse lasts one bit", io_pull_low, 0);
        if (err) begin
            chk(par_err == 1'b1, "R6 parity error flag", par_err, 1);
            chk(rx_ready == 1'b0, "R6 no ready on bad char", rx_ready, 0);
            chk(rx_data == last_good, "R6 rx_data kept", rx_data, last_good);
            pulse_clr();
            chk(par_err == 1'b0, "R11 flag_clr clears par_err", par_err, 0);
        end else begin
            chk(rx_ready == 1'b1, "R5 ready on good char", rx_ready, 1);
            chk(rx_data == d, msb ? "R3 rx msb-first data" : "R5 rx data", rx_data, d);
            chk(par_err == 1'b0, "R2 rx parity accepted", par_err, 0);
            last_good = d;
            rx_rd = 1'b1; ticks(1); rx_rd = 1'b0; ticks(1);
            chk(rx_ready == 1'b0, "R5 read clears ready", rx_ready, 0);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        int c, prev, per;
        logic drove;
        ticks(6);
        // R10: reset state
        chk(tx_empty == 1'b1, "R10 tx_empty at reset", tx_empty, 1);
        chk(rx_ready == 1'b0, "R10 rx_ready at reset", rx_ready, 0);
        chk(par_err == 1'b0 && nack_seen == 1'b0, "R10 flags at reset",
            {par_err, nack_seen}, 0);
        chk(io_pull_low == 1'b0, "R10 line released at reset", io_pull_low, 0);
        chk(card_clk == 1'b0, "R10 card clock low at reset", card_clk, 0);
        rst_n = 1'b1;
        ticks(4);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            msb_first = v[2];
            par_inv   = v[1];
            if (!v[11]) begin
                tx_data = v[10:3];
                tx_wr = 1'b1; ticks(1); tx_wr = 1'b0;
                tx_en = 1'b1;
                tx_capture(v[10:3], v[2], v[1], v[0]);
                tx_en = 1'b0;
                if (v[0]) begin
                    pulse_clr();
                    chk(nack_seen == 1'b0, "R11 flag_clr clears nack", nack_seen, 0);
                end
            end else begin
                rx_en = 1'b1;
                ticks(4);
                rx_send(v[10:3], v[2], v[1], v[0]);
                rx_en = 1'b0;
            end
            ticks(BIT);
        end

        // R7: write while full is ignored
        msb_first = 1'b0; par_inv = 1'b0;
        tx_data = 8'h96; tx_wr = 1'b1; ticks(1); tx_wr = 1'b0;
        chk(tx_empty == 1'b0, "R7 full after write", tx_empty, 0);
        tx_data = 8'h11; tx_wr = 1'b1; ticks(1); tx_wr = 1'b0;
        tx_en = 1'b1;
        tx_capture(8'h96, 1'b0, 1'b0, 1'b0);
        tx_en = 1'b0;
        ticks(BIT);

        // R8: both directions enabled, transmitter must wait
        rx_en = 1'b1; tx_en = 1'b1;
        tx_data = 8'h42; tx_wr = 1'b1; ticks(1); tx_wr = 1'b0;
        drove = 1'b0;
        for (int k = 0; k < 3 * BIT; k++) begin
            ticks(1);
            if (io_pull_low) drove = 1'b1;
        end
        chk(drove == 1'b0, "R8 no drive with both enabled", drove, 0);
        chk(tx_empty == 1'b0, "R8 byte held while both enabled", tx_empty, 0);
        rx_en = 1'b0;
        tx_capture(8'h42, 1'b0, 1'b0, 1'b0);
        tx_en = 1'b0;

        // R9: card clock period
        c = 0; prev = card_clk; per = 0;
        for (int k = 0; k < 40; k++) begin
            ticks(1);
            c++;
            if (card_clk && !prev) begin
                if (per > 0) c = c; 
                per++;
                if (per == 2) chk(c == 2 * CKH, "R9 card clock period", c, 2 * CKH);
                c = 0;
            end
            prev = card_clk;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule